// File: doc/BRIEF.md
# Single-Wire Transaction Responder

This block answers transactions on a bidirectional single-wire link that is pulled high when nobody drives it. It sits idle with its driver off and wakes on a falling edge of the line. It then follows the initiator's sync pulse and reads an 8-bit identifier frame. The frame holds a 4-bit transaction index, a 3-bit population count of that index, and an even parity bit. An identifier that fails any check is dropped without a reply. A good identifier gets a two-step acknowledge, high for one bit period and then low for one bit period. After the acknowledge the responder sends its outbound bytes, releases the line for one bit period, and collects the inbound bytes from the initiator.

The host logic chooses the byte counts and the outbound data from the index the block presents on `sel_idx`. The block keeps a 4-bit result per index, and the host reads it through a port that returns the value and clears it in the same operation. All timing comes from one parameter, the number of clock cycles per bit period. Every bit received by the block is sampled in the middle of its period, after a two-stage synchronizer.

Top module: `single_wire_target`

## Requirements
- R1: After reset the line driver is off (`line_oe` = 0) and the result of every index reads 0.
- R2: A transaction starts on a falling edge of the synchronized line. The initiator holds the line low for one bit period and high for one bit period, then sends 8 frame bits MSB first, one per bit period. The first 7 bits are the index in bits [6:3] and a count in bits [2:0]. The 8th bit is even parity, equal to the XOR of the 7 bits.
- R3: A frame whose count field differs from the number of ones in the index gets no acknowledge, and the result for that index is left unchanged.
- R4: A frame whose parity bit does not match gets no acknowledge.
- R5: An index equal to or above NUM_IDX gets no acknowledge. Index NUM_IDX-1 is accepted.
- R6: For an accepted frame, the block waits half a bit period. It then drives the line high for one bit period and low for one bit period.
- R7: Right after the acknowledge, the block sends `tx_len` bytes, least significant byte of `tx_buf` first. Each byte goes out MSB first and is followed by an even parity bit. When `tx_len` is 0, the line is released right after the acknowledge.
- R8: After sending, the block keeps the line released for one bit period. It then samples `rx_len` bytes in the same 9-bit format, with bit periods back to back. It never drives while the initiator is driving.
- R9: When the last received byte ends, the result for the index becomes 8 if every byte had correct parity or if `rx_len` was 0. It becomes 2 if any byte failed parity.
- R10: When `rd_en` is high, `rd_data` shows the result of `rd_idx` on the next cycle, and that result reads 0 afterwards. A result written in the same cycle takes precedence over the clear.
- R11: At the end of each transaction, `rx_done` pulses for one cycle and `rx_buf` holds the received bytes, byte 0 in the low bits. After a transaction or an abort, the block returns to idle and can serve the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Level of the shared line |
| line_oe | output | 1 | Drive enable for the shared line |
| line_o | output | 1 | Value driven while `line_oe` is high |
| sel_idx | output | 4 | Index of the transaction in progress |
| tx_len | input | LEN_W | Outbound byte count for `sel_idx` |
| tx_buf | input | MAX_BYTES*8 | Outbound bytes for `sel_idx` |
| rx_len | input | LEN_W | Inbound byte count for `sel_idx` |
| rx_buf | output | MAX_BYTES*8 | Bytes received in the last transaction |
| rx_done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_en | input | 1 | Read-and-clear strobe for a result |
| rd_idx | input | 4 | Index to read |
| rd_data | output | 4 | Result read (0, 2 or 8) |

## Verification
The hardest case to reach is a data error late in a transaction. It needs an identifier the block accepts, a full acknowledge and outbound phase, and then a parity fault in the second inbound byte only. The bench acts as the initiator on a modelled open-drain wire. It times each bit from the cycle in which the acknowledge first appears, flips a single parity bit in the chosen inbound byte, and then reads the result back through the read-and-clear port. A monitor also compares the driver states on every clock, so any overlap between the two drivers is reported.

// File: rtl/single_wire_target.sv
module single_wire_target #(
  parameter int BIT_CYC   = 16,
  parameter int NUM_IDX   = 6,
  parameter int MAX_BYTES = 4,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int BUF_W    = MAX_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             line_oe,
  output logic             line_o,
  output logic [3:0]       sel_idx,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [BUF_W-1:0] tx_buf,
  input  logic [LEN_W-1:0] rx_len,
  output logic [BUF_W-1:0] rx_buf,
  output logic             rx_done,
  input  logic             rd_en,
  input  logic [3:0]       rd_idx,
  output logic [3:0]       rd_data
);
  localparam int HALF  = BIT_CYC / 2;
  localparam int CNT_W = $clog2(BIT_CYC);
  localparam int DEPTH = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_WHI, S_SYN, S_ID, S_AW, S_AH, S_AL, S_TX, S_TURN, S_RX
  } st_t;

  function automatic logic [2:0] pop4(input logic [3:0] v);
    pop4 = 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
  endfunction

  st_t              st;
  logic [2:0]       sy;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitn;
  logic [LEN_W-1:0] byten, txl_q, rxl_q;
  logic [8:0]       sh;
  logic [BUF_W-1:0] txb_q;
  logic             rx_bad;
  logic [3:0]       idx_q;
  logic [3:0]       stat_q [DEPTH];

  logic       lin, fall, bit_end, mid, id_ok, byte_bad, rx_last, st_we;
  logic [3:0] id_idx, st_wval;

  assign lin      = sy[1];
  assign fall     = sy[2] & ~sy[1];
  assign bit_end  = cnt == CNT_W'(BIT_CYC - 1);
  assign mid      = cnt == CNT_W'(HALF - 1);
  assign id_idx   = sh[7:4];
  assign id_ok    = (~^sh[7:0]) && (sh[3:1] == pop4(id_idx)) && (int'(id_idx) < NUM_IDX);
  assign byte_bad = ^sh;
  assign rx_last  = st == S_RX && bit_end && bitn == 4'd8 && byten == rxl_q - LEN_W'(1);
  assign st_we    = (st == S_TURN && bit_end && rxl_q == '0) || rx_last;
  assign st_wval  = (rx_last && (rx_bad || byte_bad)) ? 4'd2 : 4'd8;

  assign line_oe  = st == S_AH || st == S_AL || st == S_TX;
  assign line_o   = st == S_AH || (st == S_TX && sh[8]);
  assign sel_idx  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy      <= 3'b111;
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      byten   <= '0;
      sh      <= '0;
      txb_q   <= '0;
      txl_q   <= '0;
      rxl_q   <= '0;
      rx_bad  <= 1'b0;
      idx_q   <= '0;
      rx_buf  <= '0;
      rx_done <= 1'b0;
    end else begin
      sy      <= {sy[1:0], line_i};
      rx_done <= st_we;
      cnt     <= bit_end ? '0 : cnt + CNT_W'(1);
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (fall) st <= S_WHI;
        end
        S_WHI: begin
          cnt <= '0;
          if (lin) st <= S_SYN;
        end
        S_SYN: if (bit_end) begin
          st   <= S_ID;
          bitn <= '0;
        end
        S_ID: begin
          if (mid) sh <= {sh[7:0], lin};
          if (bit_end) begin
            bitn <= bitn + 4'd1;
            if (bitn == 4'd7) begin
              if (id_ok) begin
                st    <= S_AW;
                idx_q <= id_idx;
              end else begin
                st <= S_IDLE;
              end
            end
          end
        end
        S_AW: if (cnt == CNT_W'(HALF - 1)) begin
          st    <= S_AH;
          cnt   <= '0;
          txl_q <= tx_len;
          rxl_q <= rx_len;
          txb_q <= tx_buf;
        end
        S_AH: if (bit_end) st <= S_AL;
        S_AL: if (bit_end) begin
          bitn  <= '0;
          byten <= '0;
          if (txl_q != '0) begin
            st    <= S_TX;
            sh    <= {txb_q[7:0], ^txb_q[7:0]};
            txb_q <= txb_q >> 8;
          end else begin
            st <= S_TURN;
          end
        end
        S_TX: if (bit_end) begin
          if (bitn == 4'd8) begin
            bitn  <= '0;
            byten <= byten + LEN_W'(1);
            if (byten == txl_q - LEN_W'(1)) begin
              st <= S_TURN;
            end else begin
              sh    <= {txb_q[7:0], ^txb_q[7:0]};
              txb_q <= txb_q >> 8;
            end
          end else begin
            bitn <= bitn + 4'd1;
            sh   <= {sh[7:0], 1'b0};
          end
        end
        S_TURN: if (bit_end) begin
          bitn   <= '0;
          byten  <= '0;
          rx_bad <= 1'b0;
          st     <= (rxl_q == '0) ? S_IDLE : S_RX;
        end
        S_RX: begin
          if (mid) sh <= {sh[7:0], lin};
          if (bit_end) begin
            if (bitn == 4'd8) begin
              bitn                  <= '0;
              byten                 <= byten + LEN_W'(1);
              rx_buf[byten*8 +: 8]  <= sh[8:1];
              if (byte_bad) rx_bad  <= 1'b1;
              if (rx_last) st       <= S_IDLE;
            end else begin
              bitn <= bitn + 4'd1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stat_q[i] <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) begin
        rd_data        <= stat_q[rd_idx];
        stat_q[rd_idx] <= '0;
      end
      if (st_we) stat_q[idx_q] <= st_wval;
    end
  end

  // R6
  ack_high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> line_o);

  // R3 R4 R5
  bad_id_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ID && bit_end && bitn == 4'd7 && !id_ok) |=> (!line_oe && st == S_IDLE));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(st_we && idx_q == rd_idx)) |=> stat_q[$past(rd_idx)] == 4'd0);

  // R9
  stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == 4'd0 || rd_data == 4'd2 || rd_data == 4'd8));

  // R8
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |=> !line_oe);
endmodule

// File: tb/single_wire_target_bench.sv
module single_wire_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT   = 16;
  localparam int HALF  = BIT / 2;
  localparam int NIDX  = 6;
  localparam int MAXB  = 4;
  localparam int LEN_W = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0;
  logic ini_oe = 0, ini_o = 1;
  logic line_oe, line_o, bus, rx_done, rd_en = 0;
  logic [3:0] sel_idx, rd_idx = 0, rd_data;
  logic [LEN_W-1:0] tx_len, rx_len;
  logic [MAXB*8-1:0] tx_buf, rx_buf;
  int cyc = 0, tests = 0, fails = 0, contention = 0, rxdone_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign bus = line_oe ? line_o : (ini_oe ? ini_o : 1'b1);

  function automatic int f_tx_len(input logic [3:0] i);
    return (i == 1) ? 2 : (i == 3) ? 1 : 0;
  endfunction
  function automatic int f_rx_len(input logic [3:0] i);
    return (i == 1) ? 1 : (i == 3) ? 2 : 0;
  endfunction
  function automatic logic [7:0] f_byte(input logic [3:0] i, input int b);
    return 8'h5A ^ {i, 4'h0} ^ (8'(b) * 8'h13);
  endfunction
  function automatic logic [2:0] ones(input logic [3:0] v);
    int n = 0;
    for (int k = 0; k < 4; k++) n += int'(v[k]);
    return 3'(n);
  endfunction

  assign tx_len = LEN_W'(f_tx_len(sel_idx));
  assign rx_len = LEN_W'(f_rx_len(sel_idx));
  always_comb for (int b = 0; b < MAXB; b++) tx_buf[b*8 +: 8] = f_byte(sel_idx, b);

  single_wire_target #(.BIT_CYC(BIT), .NUM_IDX(NIDX), .MAX_BYTES(MAXB)) u_single_wire_target (
    .clk(clk), .rst_n(rst_n), .line_i(bus), .line_oe(line_oe), .line_o(line_o),
    .sel_idx(sel_idx), .tx_len(tx_len), .tx_buf(tx_buf), .rx_len(rx_len),
    .rx_buf(rx_buf), .rx_done(rx_done), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data));

  always @(negedge clk) begin
    if (ini_oe && line_oe) contention++;
    if (rx_done) rxdone_cnt++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic read_stat(input logic [3:0] i, output logic [3:0] v);
    rd_idx = i;
    rd_en  = 1;
    @(negedge clk);
    rd_en  = 0;
    v = rd_data;
  endtask

  task automatic txn(input logic [3:0] idx, input logic cnt_err, input logic par_err,
                     input logic exp_ack, input logic [7:0] rb0, input logic [7:0] rb1,
                     input logic rx_err, input string tag);
    logic [6:0] d7;
    logic [7:0] idb;
    logic [8:0] got9, w;
    logic [3:0] v;
    logic       got;
    int t, t0, rs, ntx, nrx, rc0;
    d7  = {idx, ones(idx) ^ {2'b0, cnt_err}};
    idb = {d7, (^d7) ^ par_err};
    @(negedge clk);
    t = cyc;
    ini_oe = 1; ini_o = 0;
    wait_until(t + BIT);
    ini_o = 1;
    for (int k = 0; k < 8; k++) begin
      wait_until(t + (2 + k) * BIT);
      ini_o = idb[7-k];
    end
    wait_until(t + 10 * BIT);
    ini_oe = 0; ini_o = 1;
    got = 0;
    for (int k = 0; k < 3 * BIT && !got; k++) begin
      @(negedge clk);
      if (line_oe) got = 1;
    end
    chk(got == exp_ack, {tag, " acknowledge presence"}, got, exp_ack);
    if (!got) begin
      wait_until(cyc + 2 * BIT);
      return;
    end
    t0 = cyc;
    wait_until(t0 + HALF);
    chk(bus === 1'b1, "R6 ack high phase", bus, 1);
    wait_until(t0 + BIT + HALF);
    chk(bus === 1'b0 && line_oe, "R6 ack low phase", bus, 0);
    ntx = f_tx_len(idx);
    for (int b = 0; b < ntx; b++) begin
      for (int k = 0; k < 9; k++) begin
        wait_until(t0 + (2 + 9*b + k) * BIT + HALF);
        got9[8-k] = bus;
      end
      w = {f_byte(idx, b), ^f_byte(idx, b)};
      chk(got9 == w, "R7 outbound byte with parity", got9, w);
    end
    if (ntx == 0) begin
      wait_until(t0 + 2 * BIT + HALF);
      chk(!line_oe, "R7 release after ack when nothing to send", line_oe, 0);
    end
    nrx = f_rx_len(idx);
    rs  = t0 + (3 + 9*ntx) * BIT;
    rc0 = rxdone_cnt;
    for (int b = 0; b < nrx; b++) begin
      w = (b == 0) ? {rb0, ^rb0} : {rb1, (^rb1) ^ rx_err};
      for (int k = 0; k < 9; k++) begin
        wait_until(rs + (9*b + k) * BIT);
        ini_oe = 1; ini_o = w[8-k];
      end
    end
    wait_until(rs + 9 * nrx * BIT);
    ini_oe = 0; ini_o = 1;
    wait_until(rs + 9 * nrx * BIT + 4);
    chk(rxdone_cnt == rc0 + 1, "R11 single done pulse", rxdone_cnt - rc0, 1);
    if (nrx > 0 && !rx_err) begin
      chk(rx_buf[7:0] == rb0, "R11 inbound byte 0", rx_buf[7:0], rb0);
      if (nrx > 1) chk(rx_buf[15:8] == rb1, "R8 inbound byte 1", rx_buf[15:8], rb1);
    end
    read_stat(idx, v);
    chk(v == (rx_err ? 4'd2 : 4'd8), "R9 result code", v, rx_err ? 2 : 8);
    read_stat(idx, v);
    chk(v == 4'd0, "R10 cleared after read", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!line_oe, "R1 driver off after reset", line_oe, 0);
    for (int i = 0; i < NIDX; i++) begin
      read_stat(4'(i), v);
      chk(v == 0, "R1 result zero after reset", v, 0);
    end
    txn(4'd1, 0, 0, 1, 8'hC3, 8'h00, 0, "R2 valid frame index 1");
    txn(4'd3, 1, 0, 0, 8'h00, 8'h00, 0, "R3 count mismatch");
    read_stat(4'd3, v);
    chk(v == 0, "R3 result untouched after rejected frame", v, 0);
    txn(4'd3, 0, 1, 0, 8'h00, 8'h00, 0, "R4 parity mismatch");
    txn(4'd6, 0, 0, 0, 8'h00, 8'h00, 0, "R5 index equal to limit");
    txn(4'd7, 0, 0, 0, 8'h00, 8'h00, 0, "R5 index above limit");
    txn(4'd5, 0, 0, 1, 8'h00, 8'h00, 0, "R5 last valid index");
    txn(4'd3, 0, 0, 1, 8'h81, 8'h7E, 1, "R9 parity fault in second inbound byte");
    txn(4'd3, 0, 0, 1, 8'h81, 8'h7E, 0, "R11 recovery after data error");
    txn(4'd1, 0, 0, 1, 8'h0F, 8'h00, 0, "R2 repeat index 1");
    chk(contention == 0, "R8 no overlap of drivers", contention, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule